// File: doc/BRIEF.md
# PLL Power and Isolation Sequencer

This block orders the power-up and power-down of a clock-generator core. It drives four output groups: a multi-bit core power-enable field in an always-on power domain, an isolation latch control for that domain, a multi-bit embedded power-down field inside the core's own control logic, and an enable for an optional clock gate at the top level of the chip. Each step of a sequence is applied in its own clock cycle. When a sequence ends, a single-cycle done pulse is raised.

Configuration straps say which of the three features exist: the top-level gate, the embedded power control and the always-on domain. A step whose feature is absent still takes its cycle but leaves its output unchanged. An always-on strap blocks every power-down. A request that arrives while a sequence is running is held and starts once the running sequence has finished. The analog switches and any register access are outside this block.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, core_pwr_on is all zeros, iso_latch is 1, embed_pdn is all ones, top_gate_en is 0 and seq_done is 0.
- R2: Power-down starts with the top-level gate. Two clock edges after the edge that samples dis_req, top_gate_en is 0 (if cfg_has_gate), and the core power and isolation have not yet changed.
- R3: Three edges after the sampling edge of a power-down, embed_pdn becomes all ones (if cfg_has_embed). This happens one step after the gate is cleared.
- R4: When cfg_has_domain is set, power-down sets iso_latch to 1 at edge four and clears core_pwr_on to zero at edge five. Core power never drops while isolation is released.
- R5: Power-up clears embed_pdn to zero at edge two after the sampling edge of en_req (if cfg_has_embed), before any other output changes.
- R6: At edge three of a power-up, core_pwr_on becomes all ones and iso_latch becomes 0 in the same cycle (if cfg_has_domain). At edge four, top_gate_en becomes 1 (if cfg_has_gate).
- R7: While aon_strap is 1, dis_req is discarded and all outputs keep their values.
- R8: seq_done is high for exactly one cycle. It rises together with the last step's output: edge five of a power-down, edge four of a power-up.
- R9: A request that arrives while a sequence is running is held. Its sequence starts on the edge after seq_done.
- R10: When a feature strap is 0, the outputs of that feature are never changed by either sequence.
- R11: If an enable and a disable are both waiting when the block is idle, power-up runs first and power-down runs after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Power-up request, sampled each cycle |
| dis_req | input | 1 | Power-down request, sampled each cycle |
| aon_strap | input | 1 | Always-on strap; blocks power-down |
| cfg_has_gate | input | 1 | Top-level clock gate present |
| cfg_has_embed | input | 1 | Embedded power-down control present |
| cfg_has_domain | input | 1 | Always-on domain with isolation present |
| core_pwr_on | output | PWR_W | Core power-enable field |
| iso_latch | output | 1 | Isolation latch control, 1 = isolated |
| embed_pdn | output | EPD_W | Embedded power-down field, all ones = down |
| top_gate_en | output | 1 | Top-level clock gate enable |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The checker watches properties that must hold on every cycle:
- core power only drops while isolation is already set;
- isolation is only released together with full core power;
- the top gate only closes while power and isolation are stable;
- the embedded field is set only after the gate is closed;
- the gate only opens after the embedded field is cleared;
- the done pulse never lasts two cycles.

Only the bench scenarios can show the rest:
- the exact cycle of each step;
- that a disable under the always-on strap leaves everything alone;
- that absent features keep their outputs;
- that a held request runs afterwards;
- that enable wins when both requests wait.

// File: rtl/pps_pkg.sv
// Package: shared state and step-action types for the PLL power sequencer.
// Assumes: one action is applied per clock cycle.
package pps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DN_GATE,
        ST_DN_EPD,
        ST_DN_ISO,
        ST_DN_PWR,
        ST_UP_EPD,
        ST_UP_CORE,
        ST_UP_GATE
    } pps_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_GATE_OFF,
        ACT_EPD_SET,
        ACT_ISO_SET,
        ACT_PWR_OFF,
        ACT_EPD_CLR,
        ACT_CORE_ON,
        ACT_GATE_ON
    } pps_act_e;

endpackage

// File: rtl/pps_req_hold.sv
// Module: request holder and launcher.
// Latches enable and disable requests that arrive while a sequence runs.
// When the sequencer is idle, it picks which sequence to launch; enable wins.
// A disable is dropped whenever the always-on strap is high.
// Assumes: idle is high only in the cycle the sequencer can accept a launch.
module pps_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic aon_strap,
    input  logic idle,
    output logic go_up,
    output logic go_dn
);

    logic pend_up;
    logic pend_dn;
    logic want_up;
    logic want_dn;

    // Combine live and held requests; a disable under the strap counts as none.
    always_comb begin
        want_up = en_req | pend_up;
        want_dn = (dis_req | pend_dn) & ~aon_strap;
        go_up   = idle & want_up;
        go_dn   = idle & ~want_up & want_dn;
    end

    // Hold requests until they are launched; discard disables under the strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_up <= 1'b0;
            pend_dn <= 1'b0;
        end else begin
            pend_up <= go_up ? 1'b0 : want_up;
            pend_dn <= go_dn ? 1'b0 : want_dn;
        end
    end

endmodule

// File: rtl/pps_step_fsm.sv
// Module: step sequencer.
// Walks four power-down steps or three power-up steps, one per cycle,
// and emits the action for the current step and a done pulse.
// Assumes: go_up and go_dn are never both high.
module pps_step_fsm
    import pps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_up,
    input  logic     go_dn,
    output logic     idle,
    output pps_act_e act,
    output logic     done
);

    pps_state_e state;
    pps_state_e state_nx;

    // Next-state choice: the step chain, or a launch from idle.
    always_comb begin
        unique case (state)
            ST_IDLE:    state_nx = go_dn ? ST_DN_GATE : (go_up ? ST_UP_EPD : ST_IDLE);
            ST_DN_GATE: state_nx = ST_DN_EPD;
            ST_DN_EPD:  state_nx = ST_DN_ISO;
            ST_DN_ISO:  state_nx = ST_DN_PWR;
            ST_DN_PWR:  state_nx = ST_IDLE;
            ST_UP_EPD:  state_nx = ST_UP_CORE;
            ST_UP_CORE: state_nx = ST_UP_GATE;
            ST_UP_GATE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Action applied at the end of the current step.
    always_comb begin
        unique case (state)
            ST_DN_GATE: act = ACT_GATE_OFF;
            ST_DN_EPD:  act = ACT_EPD_SET;
            ST_DN_ISO:  act = ACT_ISO_SET;
            ST_DN_PWR:  act = ACT_PWR_OFF;
            ST_UP_EPD:  act = ACT_EPD_CLR;
            ST_UP_CORE: act = ACT_CORE_ON;
            ST_UP_GATE: act = ACT_GATE_ON;
            default:    act = ACT_NONE;
        endcase
    end

    assign idle = (state == ST_IDLE);

    // State register and done pulse on the last step of either chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_DN_PWR) || (state == ST_UP_GATE);
        end
    end

endmodule

// File: rtl/pps_out_regs.sv
// Module: output registers.
// Applies one step action per cycle to the power, isolation, embedded
// power-down and gate outputs. An action whose feature strap is 0 is a no-op.
// Assumes: the straps are static while a sequence runs.
module pps_out_regs
    import pps_pkg::*;
#(
    parameter int PWR_W = 2,
    parameter int EPD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pps_act_e         act,
    input  logic             has_gate,
    input  logic             has_embed,
    input  logic             has_domain,
    output logic [PWR_W-1:0] pwr,
    output logic             iso,
    output logic [EPD_W-1:0] epd,
    output logic             gate
);

    localparam logic [PWR_W-1:0] PWR_ON  = {PWR_W{1'b1}};
    localparam logic [EPD_W-1:0] EPD_OFF = {EPD_W{1'b1}};

    // Core power field and isolation latch of the always-on domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr <= '0;
            iso <= 1'b1;
        end else if (has_domain) begin
            if (act == ACT_ISO_SET) iso <= 1'b1;
            if (act == ACT_PWR_OFF) pwr <= '0;
            if (act == ACT_CORE_ON) begin
                pwr <= PWR_ON;
                iso <= 1'b0;
            end
        end
    end

    // Embedded power-down field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epd <= EPD_OFF;
        end else if (has_embed) begin
            if (act == ACT_EPD_SET) epd <= EPD_OFF;
            if (act == ACT_EPD_CLR) epd <= '0;
        end
    end

    // Top-level clock gate enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
        end else if (has_gate) begin
            if (act == ACT_GATE_OFF) gate <= 1'b0;
            if (act == ACT_GATE_ON)  gate <= 1'b1;
        end
    end

endmodule

// File: rtl/pll_pwr_seq.sv
// Module: PLL power and isolation sequencer (top).
// Power-down order: gate, embedded field, isolation, core power.
// Power-up order: embedded field, core power with isolation release, gate.
// Assumes: synchronous active-low reset; straps change only while idle.
module pll_pwr_seq
    import pps_pkg::*;
#(
    parameter int PWR_W = 2,
    parameter int EPD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic             aon_strap,
    input  logic             cfg_has_gate,
    input  logic             cfg_has_embed,
    input  logic             cfg_has_domain,
    output logic [PWR_W-1:0] core_pwr_on,
    output logic             iso_latch,
    output logic [EPD_W-1:0] embed_pdn,
    output logic             top_gate_en,
    output logic             seq_done
);

    logic     idle;
    logic     go_up;
    logic     go_dn;
    pps_act_e act;

    pps_req_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .aon_strap (aon_strap),
        .idle      (idle),
        .go_up     (go_up),
        .go_dn     (go_dn)
    );

    pps_step_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .go_up (go_up),
        .go_dn (go_dn),
        .idle  (idle),
        .act   (act),
        .done  (seq_done)
    );

    pps_out_regs #(.PWR_W(PWR_W), .EPD_W(EPD_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .has_gate   (cfg_has_gate),
        .has_embed  (cfg_has_embed),
        .has_domain (cfg_has_domain),
        .pwr        (core_pwr_on),
        .iso        (iso_latch),
        .epd        (embed_pdn),
        .gate       (top_gate_en)
    );

endmodule

// File: rtl/pps_chk.sv
// Module: checker for the PLL power sequencer, attached by bind.
// Watches port-level ordering properties on every cycle.
module pps_chk #(
    parameter int PWR_W = 2,
    parameter int EPD_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_has_gate,
    input logic             cfg_has_embed,
    input logic [PWR_W-1:0] core_pwr_on,
    input logic             iso_latch,
    input logic [EPD_W-1:0] embed_pdn,
    input logic             top_gate_en,
    input logic             seq_done
);

    // R1: the first cycle after reset shows the powered-down, isolated state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (core_pwr_on == '0 && iso_latch && embed_pdn == '1 &&
                           !top_gate_en && !seq_done));

    // R2: the gate closes while core power and isolation stay put.
    p_gate_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_gate_en) |-> ($stable(core_pwr_on) && $stable(iso_latch)));

    // R3: the embedded field is set only with the gate already closed.
    p_epd_after_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(embed_pdn == '1) && cfg_has_gate) |-> !top_gate_en);

    // R4: core power drops only when isolation was already set.
    p_iso_before_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_pwr_on == '0 && $past(core_pwr_on) != '0) |-> $past(iso_latch));

    // R5: the gate opens only with the embedded field already cleared.
    p_gate_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(top_gate_en) && cfg_has_embed) |-> (embed_pdn == '0));

    // R6: isolation is released only together with full core power.
    p_iso_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_latch) |-> (core_pwr_on == '1));

    // R8: the done pulse lasts a single cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

endmodule

bind pll_pwr_seq pps_chk #(.PWR_W(PWR_W), .EPD_W(EPD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_has_gate  (cfg_has_gate),
    .cfg_has_embed (cfg_has_embed),
    .core_pwr_on   (core_pwr_on),
    .iso_latch     (iso_latch),
    .embed_pdn     (embed_pdn),
    .top_gate_en   (top_gate_en),
    .seq_done      (seq_done)
);

// File: tb/tb_pll_pwr_seq.sv
module tb_pll_pwr_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0;
    logic       dis_req = 1'b0;
    logic       aon_strap = 1'b0;
    logic       cfg_has_gate = 1'b1;
    logic       cfg_has_embed = 1'b1;
    logic       cfg_has_domain = 1'b1;
    logic [1:0] core_pwr_on;
    logic       iso_latch;
    logic [2:0] embed_pdn;
    logic       top_gate_en;
    logic       seq_done;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    pll_pwr_seq #(.PWR_W(2), .EPD_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .aon_strap(aon_strap), .cfg_has_gate(cfg_has_gate),
        .cfg_has_embed(cfg_has_embed), .cfg_has_domain(cfg_has_domain),
        .core_pwr_on(core_pwr_on), .iso_latch(iso_latch), .embed_pdn(embed_pdn),
        .top_gate_en(top_gate_en), .seq_done(seq_done)
    );

    // Output snapshot packed as {pwr[1:0], iso, epd[2:0], gate}.
    function automatic logic [6:0] snap();
        return {core_pwr_on, iso_latch, embed_pdn, top_gate_en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && seq_done) done_cnt++;

    // Pulse a request for one sampling edge; returns just after that edge.
    task automatic pulse(input logic up, input logic dn);
        @(negedge clk);
        en_req  = up;
        dis_req = dn;
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Vector fields: [15:14] kind (1 up, 2 down), [13:10] {aon,gate,embed,domain},
    // [9:3] expected snapshot, [2:0] expected done pulses.
    localparam logic [15:0] VEC [7] = '{
        {2'd1, 4'b0111, 7'b11_0_000_1, 3'd1},
        {2'd2, 4'b1111, 7'b11_0_000_1, 3'd0},
        {2'd2, 4'b0111, 7'b00_1_111_0, 3'd1},
        {2'd1, 4'b0011, 7'b11_0_000_0, 3'd1},
        {2'd2, 4'b0101, 7'b00_1_000_0, 3'd1},
        {2'd1, 4'b0110, 7'b00_1_000_1, 3'd1},
        {2'd2, 4'b0111, 7'b00_1_111_0, 3'd1}
    };

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        wait_edges(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", snap(), 7'b00_1_111_0);
        check("R1 reset done", seq_done, 0);

        // Table walk: R7 aon ignore, R10 absent features, R8 done counts.
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            {aon_strap, cfg_has_gate, cfg_has_embed, cfg_has_domain} = VEC[v][13:10];
            done_cnt = 0;
            pulse(VEC[v][15:14] == 2'd1, VEC[v][15:14] == 2'd2);
            wait_edges(8);
            check($sformatf("R7/R10 vector %0d outputs", v), snap(), VEC[v][9:3]);
            check($sformatf("R8 vector %0d done count", v), done_cnt, VEC[v][2:0]);
        end

        // Power-up step timing (R5, R6, R8) from the down state.
        aon_strap = 0; cfg_has_gate = 1; cfg_has_embed = 1; cfg_has_domain = 1;
        pulse(1, 0);                      // after edge 1
        @(negedge clk);                   // edge 2
        check("R5 epd cleared first", snap(), 7'b00_1_000_0);
        @(negedge clk);                   // edge 3
        check("R6 core on and iso release", snap(), 7'b11_0_000_0);
        check("R8 no early done", seq_done, 0);
        @(negedge clk);                   // edge 4
        check("R6 gate last", snap(), 7'b11_0_000_1);
        check("R8 done with last up step", seq_done, 1);
        @(negedge clk);
        check("R8 done one cycle", seq_done, 0);

        // Power-down step timing (R2, R3, R4, R8).
        pulse(0, 1);
        @(negedge clk);
        check("R2 gate cleared first", snap(), 7'b11_0_000_0);
        @(negedge clk);
        check("R3 epd set", snap(), 7'b11_0_111_0);
        @(negedge clk);
        check("R4 iso set before power off", snap(), 7'b11_1_111_0);
        check("R8 no early done down", seq_done, 0);
        @(negedge clk);
        check("R4 power off", snap(), 7'b00_1_111_0);
        check("R8 done with last down step", seq_done, 1);

        // Held request (R9): disable arrives mid power-up.
        wait_edges(2);
        done_cnt = 0;
        pulse(1, 0);                      // edge 1
        @(negedge clk);                   // edge 2
        dis_req = 1'b1;
        @(negedge clk);                   // edge 3 samples disable while busy
        dis_req = 1'b0;
        @(negedge clk);                   // edge 4
        check("R9 up finishes first", top_gate_en, 1);
        @(negedge clk);                   // edge 5: held down launches
        @(negedge clk);                   // edge 6
        check("R9 held down starts after done", top_gate_en, 0);
        wait_edges(6);
        check("R9 final state", snap(), 7'b00_1_111_0);
        check("R9 two done pulses", done_cnt, 2);

        // Both requests together (R11): up first, then down.
        done_cnt = 0;
        pulse(1, 1);
        wait_edges(3);                    // edge 4
        check("R11 enable runs first", top_gate_en, 1);
        wait_edges(8);
        check("R11 disable runs after", snap(), 7'b00_1_111_0);
        check("R11 two done pulses", done_cnt, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule